// File: doc/BRIEF.md
# Smooth Gain Controller

This block scales a stereo stream of signed PCM samples by a programmable attenuation. Software writes an 8-bit code into a target register. The gain actually in use comes from a separate working register. On each sample-rate strobe the working register moves one code toward the effective target, so a change of setting becomes a short ramp instead of a step that would click.

Mute makes the effective target code 0. The block ramps down to silence and then stays there. When mute is released it ramps back to the stored target, which mute never overwrites. Targets written while a ramp is in progress, or while muted, are accepted at once. The ramp then simply carries on from wherever the working code stands.

A small three-state machine holds the ramp direction:
- `RAMP_HOLD`: working code equals the effective target.
- `RAMP_RISE`: working code is below the effective target.
- `RAMP_FALL`: working code is above the effective target.

After every clock edge the state is recomputed from the new working code and the new effective target. The named transitions are *settle* (to HOLD), *climb* (to RISE) and *descend* (to FALL). Any state can take any of these transitions, so a reversal in mid-ramp is a direct RISE↔FALL move.

Top module: `smooth_gain_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the target and working codes to 255. It also clears `ramp_busy` and both sample outputs.
- R2: When `tgt_we` is high at a clock edge, `tgt_code` is stored as the target. The gain already in use does not change at that edge, because the samples scaled at a strobe in the same cycle use the old working code.
- R3: The working code changes only at a clock edge where `fs_strobe` is high, and by exactly one code. It goes up when it is below the effective target, down when above, and stays put when equal (states RISE, FALL, HOLD).
- R4: A target written before the ramp finishes redirects the ramp. The ramp continues from the current working code, reversing direction if needed.
- R5: While mute is high the effective target is code 0. The working code ramps down one code per strobe, and once it reaches 0 both outputs are exactly zero. If mute is toggled in mid-ramp, the direction reverses cleanly.
- R6: When mute is released, the working code ramps back to the most recently written target, including a target written during mute.
- R7: `ramp_busy` is high after an edge exactly when the working code differs from the effective target. The effective target is 0 if `mute` was high at that edge, and otherwise the target code.
- R8: For working code c < 255 the output is (x·g + 32768) >>> 16, where g = floor(c·65535/255) = 257·c and x is the input sample. For c = 255 the output equals x exactly.
- R9: The magnitude of an output sample never exceeds the magnitude of the input sample it came from.
- R10: Outputs are loaded at the edge where `fs_strobe` is high and use the working code from before that edge's step. They hold their value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tgt_we | input | 1 | Write strobe for the target code |
| tgt_code | input | 8 | Target attenuation code (255 = unity, 0 = silent) |
| mute | input | 1 | Mute request, level sensitive |
| fs_strobe | input | 1 | One-cycle pulse per stereo sample period |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_l | output | 24 | Left scaled sample, registered |
| out_r | output | 24 | Right scaled sample, registered |
| ramp_busy | output | 1 | Working code differs from effective target |

## Verification
The bench uses the default widths: 8-bit code, 16-bit gain and 24-bit samples. With an 8-bit code, one full descending ramp visits every one of the 256 gain codes, so the scaling rule is checked at every code. Those samples include both full-scale extremes and values of mixed sign. Further ramps exercise retargeting, mute entry and release, writes during mute, a mute toggled in mid-ramp, and writes that coincide with a strobe. Every cycle is compared against an arithmetic model of the target, the working code and the registered mute.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    // Direction of the working-code ramp
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_RISE = 2'd1,
        RAMP_FALL = 2'd2
    } ramp_state_e;

endpackage

// File: rtl/sgc_ramp_fsm.sv
module sgc_ramp_fsm
    import sgc_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              mute,
    input  logic              strobe,
    output logic [CODE_W-1:0] work_code,
    output logic [CODE_W-1:0] tgt_code,
    output logic              mute_q,
    output ramp_state_e       state,
    output logic              busy
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    ramp_state_e       state_q, state_d;
    logic [CODE_W-1:0] work_q, work_d;
    logic [CODE_W-1:0] tgt_q, tgt_d;
    logic [CODE_W-1:0] eff_d;
    logic              step_up, step_dn;

    // Output process: the current state decides the step taken on a strobe
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (state_q)
            RAMP_HOLD: begin
                step_up = 1'b0;
                step_dn = 1'b0;
            end
            RAMP_RISE: step_up = strobe;
            RAMP_FALL: step_dn = strobe;
            default: begin
                step_up = 1'b0;
                step_dn = 1'b0;
            end
        endcase
    end

    // Next working code, next target and next effective target
    always_comb begin
        if (step_up) begin
            work_d = work_q + CODE_ONE;
        end else if (step_dn) begin
            work_d = work_q - CODE_ONE;
        end else begin
            work_d = work_q;
        end
        tgt_d = wr_en ? wr_code : tgt_q;
        eff_d = mute ? '0 : tgt_d;
    end

    // Transition selection: settle, climb or descend
    always_comb begin
        if (work_d < eff_d) begin
            state_d = RAMP_RISE;
        end else if (work_d > eff_d) begin
            state_d = RAMP_FALL;
        end else begin
            state_d = RAMP_HOLD;
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RAMP_HOLD;
            work_q  <= CODE_MAX;
            tgt_q   <= CODE_MAX;
            mute_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            work_q  <= work_d;
            tgt_q   <= tgt_d;
            mute_q  <= mute;
        end
    end

    assign work_code = work_q;
    assign tgt_code  = tgt_q;
    assign state     = state_q;
    assign busy      = (state_q != RAMP_HOLD);

endmodule

// File: rtl/sgc_gain_lut.sv
module sgc_gain_lut #(
    parameter int CODE_W = 8,
    parameter int GAIN_W = 16
) (
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);

    localparam int    N_CODES  = 1 << CODE_W;
    localparam longint CODE_TOP = longint'(N_CODES) - 1;
    localparam longint GAIN_TOP = (longint'(1) << GAIN_W) - 1;

    logic [GAIN_W-1:0] rom [N_CODES];

    // Linear map: code 0 -> 0, top code -> full-scale gain
    for (genvar c = 0; c < N_CODES; c++) begin : g_rom
        assign rom[c] = GAIN_W'((longint'(c) * GAIN_TOP) / CODE_TOP);
    end

    assign gain = rom[code];

endmodule

// File: rtl/sgc_scaler.sv
module sgc_scaler #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic        [GAIN_W-1:0]   gain,
    input  logic                       unity,
    output logic signed [SAMPLE_W-1:0] dout
);

    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

    logic signed [PROD_W-1:0]   din_x, gain_x, prod, rnd;
    logic signed [SAMPLE_W-1:0] scaled;
    logic                       rnd_unused;

    always_comb begin
        din_x  = PROD_W'(din);
        gain_x = PROD_W'({1'b0, gain});
        prod   = din_x * gain_x;
        rnd    = prod + (PROD_W'(1) <<< (GAIN_W - 1));
        scaled = rnd[GAIN_W +: SAMPLE_W];
    end

    assign rnd_unused = ^{rnd[GAIN_W-1:0], rnd[PROD_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (load) begin
            dout <= unity ? din : scaled;
        end
    end

endmodule

// File: rtl/smooth_gain_ctrl.sv
module smooth_gain_ctrl
    import sgc_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int GAIN_W   = 16,
    parameter int SAMPLE_W = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tgt_we,
    input  logic [CODE_W-1:0]          tgt_code,
    input  logic                       mute,
    input  logic                       fs_strobe,
    input  logic signed [SAMPLE_W-1:0] in_l,
    input  logic signed [SAMPLE_W-1:0] in_r,
    output logic signed [SAMPLE_W-1:0] out_l,
    output logic signed [SAMPLE_W-1:0] out_r,
    output logic                       ramp_busy
);

    localparam int N_CH = 2;

    logic [CODE_W-1:0]          work_code;
    logic [CODE_W-1:0]          tgt_q;
    logic                       mute_q;
    ramp_state_e                state_q;
    logic [GAIN_W-1:0]          gain;
    logic                       unity;
    logic signed [SAMPLE_W-1:0] ch_in  [N_CH];
    logic signed [SAMPLE_W-1:0] ch_out [N_CH];

    sgc_ramp_fsm #(.CODE_W(CODE_W)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (tgt_we),
        .wr_code   (tgt_code),
        .mute      (mute),
        .strobe    (fs_strobe),
        .work_code (work_code),
        .tgt_code  (tgt_q),
        .mute_q    (mute_q),
        .state     (state_q),
        .busy      (ramp_busy)
    );

    sgc_gain_lut #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_lut (
        .code (work_code),
        .gain (gain)
    );

    assign unity    = (work_code == '1);
    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        sgc_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scl (
            .clk   (clk),
            .rst   (rst),
            .load  (fs_strobe),
            .din   (ch_in[ch]),
            .gain  (gain),
            .unity (unity),
            .dout  (ch_out[ch])
        );
    end

    assign out_l = ch_out[0];
    assign out_r = ch_out[1];

endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
    parameter int CODE_W   = 8,
    parameter int SAMPLE_W = 24
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       fs_strobe,
    input logic signed [SAMPLE_W-1:0] in_l,
    input logic signed [SAMPLE_W-1:0] in_r,
    input logic signed [SAMPLE_W-1:0] out_l,
    input logic signed [SAMPLE_W-1:0] out_r,
    input logic                       ramp_busy,
    input logic [CODE_W-1:0]          work,
    input logic [CODE_W-1:0]          tgt,
    input logic                       mute_q,
    input logic [1:0]                 state
);

    function automatic longint mag(input logic signed [SAMPLE_W-1:0] v);
        longint t;
        t = longint'(v);
        return (t < 0) ? -t : t;
    endfunction

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_seen) begin
            reset_state_chk: assert (work == '1 && tgt == '1 && !ramp_busy
                                     && out_l == '0 && out_r == '0);
        end
    end

    // R3
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fs_strobe |=> $stable(work));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        fs_strobe |=> (work == $past(work) || work == $past(work) + CODE_W'(1)
                       || work == $past(work) - CODE_W'(1)));

    // R3
    state_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (state != 2'd3) && ((state == 2'd1) -> (work < (mute_q ? '0 : tgt)))
        && ((state == 2'd2) -> (work > (mute_q ? '0 : tgt))));

    // R7
    busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        ramp_busy == (work != (mute_q ? '0 : tgt)));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fs_strobe |=> (mag(out_l) <= mag($past(in_l)) && mag(out_r) <= mag($past(in_r))));

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!fs_strobe && !rst) |=> ($stable(out_l) && $stable(out_r)));

    // R5
    mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_strobe && work == '0) |=> (out_l == '0 && out_r == '0));

endmodule

bind smooth_gain_ctrl sgc_checker #(.CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fs_strobe (fs_strobe),
    .in_l      (in_l),
    .in_r      (in_r),
    .out_l     (out_l),
    .out_r     (out_r),
    .ramp_busy (ramp_busy),
    .work      (work_code),
    .tgt       (tgt_q),
    .mute_q    (mute_q),
    .state     (state_q)
);

// File: tb/sim_smooth_gain_ctrl.sv
`timescale 1ns/1ps
module sim_smooth_gain_ctrl;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tgt_we = 1'b0;
    logic [7:0]         tgt_code = 8'd0;
    logic               mute = 1'b0;
    logic               fs_strobe = 1'b0;
    logic signed [23:0] in_l = '0;
    logic signed [23:0] in_r = '0;
    logic signed [23:0] out_l, out_r;
    logic               ramp_busy;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // model state
    int m_work = 255;
    int m_tgt  = 255;
    bit m_mq   = 1'b0;
    longint e_l = 0;
    longint e_r = 0;

    always #2 clk = ~clk;

    smooth_gain_ctrl u0 (
        .clk(clk), .rst(rst), .tgt_we(tgt_we), .tgt_code(tgt_code), .mute(mute),
        .fs_strobe(fs_strobe), .in_l(in_l), .in_r(in_r),
        .out_l(out_l), .out_r(out_r), .ramp_busy(ramp_busy)
    );

    // R8 arithmetic expectation
    function automatic longint exp_scale(input longint x, input int c);
        longint g, p;
        if (c == 255) return x;
        g = (longint'(c) * 65535) / 255;
        p = x * g + 32768;
        return p >>> 16;
    endfunction

    function automatic longint absv(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input string tag, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic tick(input bit we, input int code, input bit mu, input bit stb,
                        input longint l, input longint r, input string tag);
        int eff_old, eff_new;
        @(negedge clk);
        tgt_we    = we;
        tgt_code  = 8'(code);
        mute      = mu;
        fs_strobe = stb;
        in_l      = 24'(l);
        in_r      = 24'(r);
        eff_old = m_mq ? 0 : m_tgt;
        if (stb) begin
            e_l = exp_scale(longint'(24'(l) ^ 24'h0) , m_work);
            e_l = exp_scale(longint'($signed(24'(l))), m_work);
            e_r = exp_scale(longint'($signed(24'(r))), m_work);
            if (m_work < eff_old) m_work++;
            else if (m_work > eff_old) m_work--;
        end
        if (we) m_tgt = code;
        m_mq = mu;
        eff_new = m_mq ? 0 : m_tgt;
        @(posedge clk);
        #1;
        chk({tag, " out_l"}, longint'(out_l), e_l);
        chk({tag, " out_r"}, longint'(out_r), e_r);
        chk("R7 ramp_busy", longint'(ramp_busy), longint'(m_work != eff_new));
        if (stb) begin
            chk("R9 magnitude", longint'(absv(longint'(out_l)) <= absv(longint'($signed(24'(l))))), 1);
        end
    endtask

    function automatic longint pat(input int i);
        case (i % 5)
            0: return 8388607;
            1: return -8388608;
            2: return longint'(i) * 30011 - 4000000;
            3: return -1;
            default: return 1 + longint'(i) * 77;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 out_l", longint'(out_l), 0);
        chk("R1 out_r", longint'(out_r), 0);
        chk("R1 ramp_busy", longint'(ramp_busy), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 busy after release", longint'(ramp_busy), 0);

        // R8 unity passes extremes exactly
        tick(0, 0, 0, 1, 8388607, -8388608, "R8");
        tick(0, 0, 0, 1, -5, 123456, "R8");
        // R2 write without strobe: outputs hold, busy rises
        tick(1, 0, 0, 0, 1000, 1000, "R2");
        tick(0, 0, 0, 0, 77, 77, "R3");
        // R2 write coinciding with strobe uses old working code (still 255)
        tick(1, 0, 0, 1, 4000000, -4000000, "R2");
        // R8 full sweep down through every code
        for (int i = 0; i < 260; i++) begin
            tick(0, 0, 0, 1, pat(i), -pat(i + 2), "R8");
            if (i % 37 == 0) tick(0, 0, 0, 0, 5, 5, "R10");
        end
        // R4 retarget mid-ramp
        tick(1, 200, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 50; i++) tick(0, 0, 0, 1, pat(i), pat(i + 1), "R4");
        tick(1, 20, 0, 1, 8388607, -8388608, "R4");
        for (int i = 0; i < 40; i++) tick(0, 0, 0, 1, pat(i + 3), pat(i), "R4");
        // R5 mute ramps down to silence
        tick(1, 120, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 60; i++) tick(0, 0, 0, 1, pat(i), pat(i), "R5");
        for (int i = 0; i < 90; i++) tick(0, 0, 1, 1, 8388607, -8388608, "R5");
        // R6 target written during mute is kept
        tick(1, 90, 1, 1, 12345, -12345, "R6");
        for (int i = 0; i < 5; i++) tick(0, 0, 1, 1, pat(i), pat(i), "R6");
        for (int i = 0; i < 100; i++) tick(0, 0, 0, 1, pat(i), -pat(i), "R6");
        // R5 mute toggled mid-ramp reverses
        for (int i = 0; i < 4; i++) tick(0, 0, 1, 1, pat(i), pat(i), "R5");
        tick(0, 0, 0, 0, 9, 9, "R10");
        for (int i = 0; i < 8; i++) tick(0, 0, 0, 1, pat(i), pat(i), "R5");
        // R3 ramp back up to unity
        tick(1, 255, 0, 0, 0, 0, "R3");
        for (int i = 0; i < 170; i++) tick(0, 0, 0, 1, pat(i), pat(i + 1), "R3");
        tick(0, 0, 0, 1, -8388608, 8388607, "R8");
        tick(0, 0, 0, 0, 1, 1, "R10");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule